// File: doc/BRIEF.md
# Split Decade Counter with Preset-to-Nine

This block is a four-bit counter built from two independent sections that run from one system clock: a divide-by-two section whose state is Q0, and a divide-by-five section whose state is Q3..Q1. Each section has its own count input. Both count inputs are sampled on every clock, and a high-to-low transition seen on an input advances the section it drives.

A two-bit mode input picks how the sections are linked, and the link is made inside the block. In decade mode the first input drives the divide-by-two section, whose wrap from 1 to 0 advances the divide-by-five section, which gives an 8421 count from 0 to 9. In bi-quinary mode the second input drives the divide-by-five section, whose wrap (Q3 falling) advances the divide-by-two section, so Q0 becomes a square wave with a 50% duty cycle at one tenth of the input rate. In split mode the two sections count separately.

Two gated overrides act at the level on every clock: a clear that needs both of its inputs high, and a preset-to-nine that needs both of its inputs high and wins over the clear and over any counting.

Top module: `split_decade_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `q` becomes 0000 and the stored previous values of both count inputs become 0.
- R2: In split mode (`mode` = 00 or 11), each falling edge on `cnt_a` toggles `q[0]`, and each falling edge on `cnt_b` steps `q[3:1]` through 000, 001, 010, 011, 100 and back to 000. The two inputs may fall in the same cycle.
- R3: A falling edge is an input sampled high at one clock edge and low at the next. `q` changes at that second edge. A steady level or a rising edge leaves `q` unchanged.
- R4: In decade mode (`mode` = 01), falling edges on `cnt_a` make `q` count 0 to 9 in 8421 code and then wrap to 0. Edges on `cnt_b` have no effect.
- R5: In bi-quinary mode (`mode` = 10), falling edges on `cnt_b` step `q[3:1]` as in R2, and `q[0]` toggles each time `q[3]` falls. Edges on `cnt_a` have no effect.
- R6: When `clr_a` and `clr_b` are both high and the preset is not fully asserted, `q` becomes 0000 at the next edge, whatever the count inputs do.
- R7: With only one clear input high, the block counts normally.
- R8: When `set_a` and `set_b` are both high, `q` becomes 1001 at the next edge. This holds even when both clear inputs are high and while count edges arrive.
- R9: With only one preset input high, the preset has no effect.
- R10: From a preset of nine, the next count edge gives 0000, in decade mode on `cnt_a` and in bi-quinary mode on `cnt_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Link select: 00/11 split, 01 decade, 10 bi-quinary |
| cnt_a | input | 1 | Count input of the divide-by-two section |
| cnt_b | input | 1 | Count input of the divide-by-five section |
| clr_a | input | 1 | Clear gate input A |
| clr_b | input | 1 | Clear gate input B |
| set_a | input | 1 | Preset-to-nine gate input A |
| set_b | input | 1 | Preset-to-nine gate input B |
| q | output | 4 | Counter state: q[0] is the divide-by-two section, q[3:1] the divide-by-five section |

## Verification
A count input that goes low is sampled at the next rising edge. That same edge updates `q`, including any change passed on to the other section, so each result is due one edge after the input falls. The bench changes inputs on falling clock edges and reads `q` on the falling edge after the edge that detects the transition. Clear and preset results are due one edge after both gate inputs go high, and they are read on the falling edge that follows. Checks that an edge is ignored read `q` at the same point, after the edge that would have acted on it.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [1:0] {
    LINK_SPLIT     = 2'b00,
    LINK_DECADE    = 2'b01,
    LINK_BIQUINARY = 2'b10,
    LINK_SPLIT_ALT = 2'b11
  } link_e;
endpackage

// File: rtl/sdc_fall_detect.sv
module sdc_fall_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] prev_o,
  output logic [N-1:0] fall_o
);
  always_ff @(posedge clk) begin
    if (rst) prev_o <= '0;
    else     prev_o <= sig_i;
  end

  assign fall_o = prev_o & ~sig_i;
endmodule

// File: rtl/sdc_section.sv
module sdc_section #(
  parameter int MOD        = 5,
  parameter int PRESET_VAL = 4,
  localparam int W         = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  input  logic         clr_i,
  input  logic         set_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);
  localparam logic [W-1:0] PRE  = W'(PRESET_VAL);

  logic [W-1:0] nxt;

  // Any value at or beyond the last legal one returns to zero.
  assign nxt = (q_o >= LAST) ? '0 : q_o + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)        q_o <= '0;
    else if (set_i) q_o <= PRE;
    else if (clr_i) q_o <= '0;
    else if (adv_i) q_o <= nxt;
  end

  // R2: the section never leaves its legal range.
  always_ff @(posedge clk) begin
    if (!rst) a_r2_in_range: assert (q_o <= LAST);
  end
endmodule

// File: rtl/split_decade_counter.sv
module split_decade_counter #(
  parameter int LO_MOD    = 2,
  parameter int HI_MOD    = 5,
  parameter int LO_PRESET = 1,
  parameter int HI_PRESET = 4,
  localparam int LO_W     = (LO_MOD > 1) ? $clog2(LO_MOD) : 1,
  localparam int HI_W     = (HI_MOD > 1) ? $clog2(HI_MOD) : 1,
  localparam int Q_W      = LO_W + HI_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     mode,
  input  logic           cnt_a,
  input  logic           cnt_b,
  input  logic           clr_a,
  input  logic           clr_b,
  input  logic           set_a,
  input  logic           set_b,
  output logic [Q_W-1:0] q
);
  import sdc_pkg::*;

  localparam logic [Q_W-1:0] NINE = {HI_W'(HI_PRESET), LO_W'(LO_PRESET)};

  link_e         link;
  logic [1:0]    fall, prev;
  logic          clr_all, set_all;
  logic          adv_lo, adv_hi;
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;

  assign link    = link_e'(mode);
  assign clr_all = clr_a & clr_b;
  assign set_all = set_a & set_b;

  sdc_fall_detect #(.N(2)) u_edges (
    .clk(clk), .rst(rst), .sig_i({cnt_b, cnt_a}), .prev_o(prev), .fall_o(fall)
  );

  // Carries come from external edges and current state only, so no loop.
  // The top bit of a section is high exactly when its next step wraps.
  always_comb begin
    case (link)
      LINK_DECADE: begin
        adv_lo = fall[0];
        adv_hi = fall[0] & lo_q[LO_W-1];
      end
      LINK_BIQUINARY: begin
        adv_hi = fall[1];
        adv_lo = fall[1] & hi_q[HI_W-1];
      end
      default: begin
        adv_lo = fall[0];
        adv_hi = fall[1];
      end
    endcase
  end

  sdc_section #(.MOD(LO_MOD), .PRESET_VAL(LO_PRESET)) u_lo (
    .clk(clk), .rst(rst), .adv_i(adv_lo), .clr_i(clr_all), .set_i(set_all), .q_o(lo_q)
  );

  sdc_section #(.MOD(HI_MOD), .PRESET_VAL(HI_PRESET)) u_hi (
    .clk(clk), .rst(rst), .adv_i(adv_hi), .clr_i(clr_all), .set_i(set_all), .q_o(hi_q)
  );

  assign q = {hi_q, lo_q};

  // R8: a full preset gives nine at the next edge.
  a_r8_preset_nine: assert property (@(posedge clk) disable iff (rst)
    set_all |=> (q == NINE));

  // R6: a full clear without preset gives zero.
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (clr_all && !set_all) |=> (q == '0));

  // R3: no edge and no override leaves the state alone.
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!set_all && !clr_all && (prev & ~{cnt_b, cnt_a}) == 2'b00) |=> $stable(q));

  // R4: nine wraps to zero on a decade step.
  a_r4_decade_wrap: assert property (@(posedge clk) disable iff (rst)
    (link == LINK_DECADE && !set_all && !clr_all && prev[0] && !cnt_a && q == NINE)
    |=> (q == '0));
endmodule

// File: tb/split_decade_counter_tb.sv
module split_decade_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b01;
  logic       cnt_a = 1'b0, cnt_b = 1'b0;
  logic       clr_a = 1'b0, clr_b = 1'b0, set_a = 1'b0, set_b = 1'b0;
  logic [3:0] q;
  int         errors = 0;
  int         checks = 0;

  always #10 clk = ~clk;

  split_decade_counter u_dut (
    .clk(clk), .rst(rst), .mode(mode), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .clr_a(clr_a), .clr_b(clr_b), .set_a(set_a), .set_b(set_b), .q(q)
  );

  task automatic check(input string tag, input logic [3:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q=%b expected %b", tag, q, exp);
    end
  endtask

  // Raise then drop the chosen inputs. Returns on the falling clock edge
  // after the rising edge that sees the drop.
  task automatic pulse(input bit on_a, input bit on_b);
    @(negedge clk);
    if (on_a) cnt_a = 1'b1;
    if (on_b) cnt_b = 1'b1;
    @(negedge clk);
    cnt_a = 1'b0;
    cnt_b = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr_a = 1'b1; clr_b = 1'b1;
    @(negedge clk); clr_a = 1'b0; clr_b = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", 4'd0);

    // R4: decade sweep
    mode = 2'b01;
    for (int i = 1; i <= 25; i++) begin
      pulse(1, 0);
      check("R4 decade count", 4'(i % 10));
    end
    held = q;
    pulse(0, 1);
    check("R4 cnt_b ignored in decade", held);

    // R3: steady high and a rise alone change nothing; the drop acts at one edge
    do_clear();
    @(negedge clk); cnt_a = 1'b1;
    repeat (4) @(negedge clk);
    check("R3 high level holds", 4'd0);
    cnt_a = 1'b0;
    check("R3 before detecting edge", 4'd0);
    @(negedge clk);
    check("R3 update one edge after drop", 4'd1);

    // R6: clear overrides counting
    do_clear();
    check("R6 clear", 4'd0);
    clr_a = 1'b1; clr_b = 1'b1;
    pulse(1, 0);
    check("R6 clear wins over count", 4'd0);
    clr_a = 1'b0; clr_b = 1'b0;

    // R7: single clear input does not clear
    clr_a = 1'b1;
    pulse(1, 0);
    check("R7 clr_a alone counts", 4'd1);
    clr_a = 1'b0; clr_b = 1'b1;
    pulse(1, 0);
    check("R7 clr_b alone counts", 4'd2);
    clr_b = 1'b0;

    // R5: bi-quinary sweep
    mode = 2'b10;
    do_clear();
    for (int i = 1; i <= 20; i++) begin
      pulse(0, 1);
      check("R5 bi-quinary step", {3'(i % 5), 1'((i / 5) % 2)});
    end
    held = q;
    pulse(1, 0);
    check("R5 cnt_a ignored in bi-quinary", held);

    // R2: split modes, both encodings
    for (int md = 0; md < 4; md += 3) begin
      mode = 2'(md);
      for (int n = 0; n < 4; n++) begin
        for (int m = 0; m < 7; m++) begin
          do_clear();
          for (int k = 0; k < n; k++) pulse(1, 0);
          for (int k = 0; k < m; k++) pulse(0, 1);
          check("R2 split count", {3'(m % 5), 1'(n % 2)});
        end
      end
      do_clear();
      for (int k = 1; k <= 7; k++) begin
        pulse(1, 1);
        check("R2 split simultaneous", {3'(k % 5), 1'(k % 2)});
      end
    end

    // R8: preset wins over clear and counting
    mode = 2'b01;
    do_clear();
    @(negedge clk); set_a = 1'b1; set_b = 1'b1; clr_a = 1'b1; clr_b = 1'b1;
    @(negedge clk);
    check("R8 preset over clear", 4'd9);
    pulse(1, 0);
    check("R8 preset over count", 4'd9);
    set_a = 1'b0; set_b = 1'b0; clr_a = 1'b0; clr_b = 1'b0;

    // R9: single preset input does nothing
    do_clear();
    @(negedge clk); set_a = 1'b1;
    @(negedge clk);
    check("R9 set_a alone", 4'd0);
    set_a = 1'b0; set_b = 1'b1;
    @(negedge clk);
    check("R9 set_b alone", 4'd0);
    set_b = 1'b0;

    // R10: nine rolls to zero in both linked modes
    @(negedge clk); set_a = 1'b1; set_b = 1'b1;
    @(negedge clk); set_a = 1'b0; set_b = 1'b0;
    pulse(1, 0);
    check("R10 decade nine to zero", 4'd0);
    mode = 2'b10;
    @(negedge clk); set_a = 1'b1; set_b = 1'b1;
    @(negedge clk); set_a = 1'b0; set_b = 1'b0;
    pulse(0, 1);
    check("R10 bi-quinary nine to zero", 4'd0);

    // R1: reset mid-count with an input held high clears the stored input too
    mode = 2'b01;
    pulse(1, 0); pulse(1, 0);
    @(negedge clk); cnt_a = 1'b1; rst = 1'b1;
    @(negedge clk); rst = 1'b0; cnt_a = 1'b0;
    check("R1 reset mid-count", 4'd0);
    @(negedge clk);
    check("R1 stored input cleared", 4'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule